// File: doc/BRIEF.md
# Function-Class ALU

This block is the integer ALU of a small single-issue processor datapath. One operation takes two operands, an add/subtract select, a two-bit logic function select and a two-bit function class select. The block returns a result word together with a zero flag, which branch-equality decisions use, and a signed overflow flag. The function class selects which of four results is returned: the upper-half immediate placement, the signed set-less comparison, the adder/subtractor output or the bitwise logic unit output. The ALU does not choose between register and immediate operands and does not sign-extend immediates. The stage driving it does both.

The block sits in a stream. It accepts an operation on a valid/ready handshake. It holds the computed result in a single output register until the consumer takes it. An operation is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so a full register with a stalled consumer pushes back on the producer. The producer must hold its operation steady while `in_valid` is high and `in_ready` is low. While `out_valid` is high and `out_ready` is low, the output fields do not change.

Top module: `fcls_alu`

## Requirements
- R1: With class 2'b10 (arithmetic) and `sub_sel` = 0, `result` is `opa + opb` modulo 2^32.
- R2: With class 2'b10 and `sub_sel` = 1, `result` is `opa - opb` modulo 2^32.
- R3: `ovf` is 1 only for class 2'b10. It is then 1 exactly when the signed add or subtract result falls outside the 32-bit two's complement range. For classes 2'b00, 2'b01 and 2'b11, `ovf` is 0.
- R4: With class 2'b11 (logic), `logic_sel` 2'b00 gives AND, 2'b01 gives OR, 2'b10 gives XOR and 2'b11 gives NOR of the two operands.
- R5: With class 2'b00 (upper immediate), `result` is `{opb[15:0], 16'h0000}`.
- R6: With class 2'b01 (set-less) and `sub_sel` = 1, `result` is 1 when `opa < opb` as signed numbers and 0 otherwise. This includes pairs whose difference overflows. Bits 31:1 of the result are then always 0.
- R7: `zero` is 1 exactly when the delivered `result` is all zeros.
- R8: An operation is accepted when `in_valid` and `in_ready` are both high at a rising edge. Its result appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `result`, `zero` and `ovf` stay unchanged at the next edge.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (register or immediate, already extended) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| logic_sel | input | 2 | 00 AND, 01 OR, 10 XOR, 11 NOR |
| class_sel | input | 2 | 00 upper immediate, 01 set-less, 10 arithmetic, 11 logic |
| out_valid | output | 1 | Result register holds an undelivered result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 32 | Selected result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the arithmetic class |

## Verification
Each result, together with its zero and overflow flags, becomes visible one clock edge after the edge that accepts the operation. It then stays on the outputs until the edge on which the consumer takes it. The bench drives its inputs at the falling edge and samples every output one time unit later. At that point it predicts which transfers the next rising edge will perform. A one-entry expected queue holds each accepted operation's computed result until the output handshake delivers it. The bench then checks `out_valid` against the queue's occupancy and `in_ready` against the back-pressure rule on every cycle. During stalls it also checks that the held outputs do not move.

// File: rtl/fcls_alu_pkg.sv
package fcls_alu_pkg;

  typedef enum logic [1:0] {
    CLS_UPPER   = 2'b00,
    CLS_SETLESS = 2'b01,
    CLS_ARITH   = 2'b10,
    CLS_LOGIC   = 2'b11
  } fcls_class_e;

  typedef enum logic [1:0] {
    LF_AND = 2'b00,
    LF_OR  = 2'b01,
    LF_XOR = 2'b10,
    LF_NOR = 2'b11
  } fcls_logic_e;

endpackage

// File: rtl/fcls_addsub.sv
module fcls_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         sovf,
  output logic         less
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    // signed overflow: like-signed inputs giving an unlike-signed sum
    sovf  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    // sign of the difference, corrected when it overflowed
    less  = sum[MSB] ^ sovf;
  end
endmodule

// File: rtl/fcls_logic.sv
module fcls_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] y
);
  import fcls_alu_pkg::*;

  always_comb begin
    unique case (fcls_logic_e'(fn))
      LF_AND:  y = a & b;
      LF_OR:   y = a | b;
      LF_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/fcls_select.sv
module fcls_select #(
  parameter int W = 32
) (
  input  logic [1:0]   cls,
  input  logic [W-1:0] b,
  input  logic [W-1:0] arith,
  input  logic         arith_ovf,
  input  logic         less,
  input  logic [W-1:0] logic_y,
  output logic [W-1:0] res,
  output logic         ovf
);
  import fcls_alu_pkg::*;

  localparam int HALF = W / 2;

  always_comb begin
    ovf = 1'b0;
    unique case (fcls_class_e'(cls))
      CLS_UPPER:   res = {b[HALF-1:0], {(W-HALF){1'b0}}};
      CLS_SETLESS: res = {{(W-1){1'b0}}, less};
      CLS_ARITH: begin
        res = arith;
        ovf = arith_ovf;
      end
      default:     res = logic_y;
    endcase
  end
endmodule

// File: rtl/fcls_alu.sv
module fcls_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub_sel,
  input  logic [1:0]   logic_sel,
  input  logic [1:0]   class_sel,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         ovf
);
  import fcls_alu_pkg::*;

  logic [W-1:0] sum_w, logic_w, res_w;
  logic         sovf_w, less_w, ovf_w;
  logic         in_fire;
  logic [1:0]   cls_q;

  fcls_addsub #(.W(W)) u_addsub (
    .a(opa), .b(opb), .sub(sub_sel),
    .sum(sum_w), .sovf(sovf_w), .less(less_w)
  );

  fcls_logic #(.W(W)) u_logic (
    .a(opa), .b(opb), .fn(logic_sel), .y(logic_w)
  );

  fcls_select #(.W(W)) u_select (
    .cls(class_sel), .b(opb), .arith(sum_w), .arith_ovf(sovf_w),
    .less(less_w), .logic_y(logic_w), .res(res_w), .ovf(ovf_w)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      result <= res_w;
      zero   <= (res_w == '0);
      ovf    <= ovf_w;
      cls_q  <= class_sel;
    end
  end

  // R8: an empty output register never blocks the producer
  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9: a stalled result holds its place and value
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(zero) && $stable(ovf)));

  // R3: overflow only for the arithmetic class
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls_q != CLS_ARITH) |-> !ovf);

  // R6: set-less results are a single bit
  assert_setless_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls_q == CLS_SETLESS) |-> (result[W-1:1] == '0));

  // R5: upper-immediate results have a clear low half
  assert_upper_low_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls_q == CLS_UPPER) |-> (result[W/2-1:0] == '0));

  // R7: zero flag agrees with the delivered word
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero == (result == '0)));

  // R10: nothing valid while held in reset
  assert_reset_empty_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/fcls_alu_bench.sv
module fcls_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] opa, opb, result;
  logic        sub_sel, zero, ovf;
  logic [1:0]  logic_sel, class_sel;

  always #5 clk = ~clk;

  fcls_alu u_fcls_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .sub_sel(sub_sel), .logic_sel(logic_sel),
    .class_sel(class_sel), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .zero(zero), .ovf(ovf)
  );

  typedef struct {
    logic [31:0] r;
    logic        z;
    logic        o;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          held = 0;
  logic [31:0] held_r;
  logic        held_z, held_o;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic s, input logic [1:0] lf, input logic [1:0] c);
    exp_t   e;
    longint sa, sb, wide;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e.o = 1'b0;
    case (c)
      2'b00: begin e.r = b << 16; e.tag = "R5"; end
      2'b01: begin e.r = (sa < sb) ? 32'd1 : 32'd0; e.tag = "R6"; end
      2'b10: begin
        wide  = s ? (sa - sb) : (sa + sb);
        e.r   = wide[31:0];
        e.o   = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        e.tag = s ? "R2" : "R1";
      end
      default: begin
        case (lf)
          2'b00: e.r = a & b;
          2'b01: e.r = a | b;
          2'b10: e.r = a ^ b;
          default: e.r = ~(a | b);
        endcase
        e.tag = "R4";
      end
    endcase
    e.z = (e.r == 32'd0);
    return e;
  endfunction

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b, input logic s,
                      input logic [1:0] lf, input logic [1:0] c, input bit ordy, output bit took);
    exp_t e;
    @(negedge clk);
    in_valid = v; opa = a; opb = b; sub_sel = s; logic_sel = lf; class_sel = c;
    out_ready = ordy;
    #1;
    chk(out_valid == (q.size() != 0), "R8 out_valid", {31'd0, out_valid}, {31'd0, q.size() != 0});
    chk(in_ready == (!out_valid || out_ready), "R8 in_ready", {31'd0, in_ready},
        {31'd0, !out_valid || out_ready});
    if (held) begin
      chk(out_valid && result == held_r && zero == held_z && ovf == held_o, "R9 hold",
          result, held_r);
      held = 0;
    end
    if (out_valid && !out_ready) begin
      held = 1; held_r = result; held_z = zero; held_o = ovf;
    end
    if (out_valid && out_ready && q.size() != 0) begin
      e = q.pop_front();
      chk(result == e.r, e.tag, result, e.r);
      chk(zero == e.z, "R7", {31'd0, zero}, {31'd0, e.z});
      chk(ovf == e.o, "R3", {31'd0, ovf}, {31'd0, e.o});
    end
    took = v && in_ready;
    if (took) q.push_back(model(a, b, s, lf, c));
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s,
                      input logic [1:0] lf, input logic [1:0] c, input bit rnd_ready);
    bit took;
    took = 0;
    while (!took) step(1'b1, a, b, s, lf, c, rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1, took);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h7fff_ffff;
      1: return 32'h8000_0000;
      2: return 32'hffff_ffff;
      3: return 32'd0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    bit t;
    rst_n = 0; in_valid = 0; out_ready = 0;
    opa = 0; opb = 0; sub_sel = 0; logic_sel = 0; class_sel = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R10 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1;

    // directed corners: R1 R2 R3 R4 R5 R6 R7
    send(32'd5, 32'd7, 1'b0, 2'b00, 2'b10, 0);           // R1 plain add
    send(32'h7fff_ffff, 32'd1, 1'b0, 2'b00, 2'b10, 0);   // R1 R3 positive overflow
    send(32'h8000_0000, 32'd1, 1'b1, 2'b00, 2'b10, 0);   // R2 R3 negative overflow
    send(32'h1234_5678, 32'h1234_5678, 1'b1, 2'b00, 2'b10, 0); // R2 R7 zero difference
    send(32'hffff_ffff, 32'd1, 1'b0, 2'b00, 2'b10, 0);   // R1 carry without overflow
    send(32'hf0f0_1234, 32'h0ff0_00ff, 1'b0, 2'b00, 2'b11, 0); // R4 AND
    send(32'hf0f0_1234, 32'h0ff0_00ff, 1'b0, 2'b01, 2'b11, 0); // R4 OR
    send(32'hf0f0_1234, 32'h0ff0_00ff, 1'b0, 2'b10, 2'b11, 0); // R4 XOR
    send(32'hf0f0_1234, 32'h0ff0_00ff, 1'b0, 2'b11, 2'b11, 0); // R4 NOR
    send(32'hffff_ffff, 32'h0000_0000, 1'b0, 2'b11, 2'b11, 0); // R4 R7 NOR gives zero
    send(32'hdead_beef, 32'h5555_abcd, 1'b0, 2'b00, 2'b00, 0); // R5 upper placement
    send(32'hfffffffb, 32'd3, 1'b1, 2'b00, 2'b01, 0);    // R6 -5 < 3
    send(32'd3, 32'hfffffffb, 1'b1, 2'b00, 2'b01, 0);    // R6 3 < -5 false
    send(32'h8000_0000, 32'h7fff_ffff, 1'b1, 2'b00, 2'b01, 0); // R6 overflowing difference
    send(32'h7fff_ffff, 32'h8000_0000, 1'b1, 2'b00, 2'b01, 0); // R6 overflowing difference
    send(32'h7fff_ffff, 32'h8000_0000, 1'b1, 2'b00, 2'b11, 0); // R3 no flag in logic class

    // random traffic with bubbles and stalls: R8 R9 and all functions
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] c;
      c = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0)
        step(1'b0, 32'd0, 32'd0, 1'b0, 2'b00, 2'b00, $urandom_range(0, 1) != 0, t);
      else
        send(pick(), pick(), (c == 2'b01) ? 1'b1 : 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)), c, 1);
    end
    repeat (4) step(1'b0, 32'd0, 32'd0, 1'b0, 2'b00, 2'b00, 1'b1, t);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule